// File: doc/BRIEF.md
# SD Host Interrupt Enable, Status and Error Classifier

This block holds the interrupt enable mask and the sticky interrupt status of an SD/MMC host controller. Hardware event pulses from the command path, the data path, the FIFOs and the DMA engine set status bits. A write-one-to-clear port removes status bits. A level interrupt is raised whenever an enabled bit is pending. The card bus, the FIFOs and the DMA engine are not part of the block; each appears only as an event input.

When a command starts, the block loads the enable mask itself. The mask holds every error event and exactly one completion event. The completion event is chosen from three inputs: whether the command moves data, the transfer direction, and a flush-mode strap. Starting a command also clears all pending status. Finishing a request empties both the mask and the status. From the pending status the block derives a 2-bit command-error code and a 2-bit data-error code, each by a fixed priority. It also raises a flag once the chosen completion event has arrived.

Top module: `sdh_irq_top`

## Requirements
- R1: `irq` is high exactly when some bit is set in both the enable mask and the status register, and it follows them at once as a level.
- R2: A `clr_wr` cycle clears, in the next cycle, every status bit whose `clr_data` bit is one. Status bits whose `clr_data` bit is zero are left unchanged.
- R3: An event pulse sets its status bit in the next cycle. An event wins over any clear that occurs in the same cycle, whether the clear comes from `clr_wr`, `cmd_start` or `req_done`.
- R4: An `en_wr` cycle loads `en_wdata` into the enable mask in the next cycle.
- R5: A `cmd_start` cycle clears all status bits and captures data presence and direction. It loads the mask with the six error events (bits 1 to 6, 9'h07E) plus the completion event.
- R6: Status bit layout: 0 response ok, 1 response CRC, 2 response timeout, 3 data CRC, 4 data timeout, 5 RX FIFO full, 6 TX FIFO empty, 7 DMA done, 8 transfer ok. `cmd_err` is encoded as follows: 1 (I/O) if bit 5 or bit 6 is set; otherwise 2 (CRC) if bit 1 is set; otherwise 3 (timeout) if bit 2 is set; otherwise 0.
- R7: `dat_err` is 0 unless the current command carries data. When it does, `dat_err` is 2 if bit 3 is set, otherwise 3 if bit 4 is set, otherwise 0.
- R8: `cmp_sel` names the completion event: 0 (bit 0) for a command without data; 1 (bit 7) for a data command that is a write or has `hw_flush` high; 2 (bit 8) otherwise. `req_end` is high while that status bit is set.
- R9: A `req_done` cycle empties the enable mask, clears all status bits and forgets the data context.
- R10: After reset the mask, the status, `irq`, `cmd_err`, `dat_err`, `cmp_sel` and `req_end` are all zero.
- R11: If several control inputs occur in the same cycle, `req_done` takes precedence over `cmd_start`, and `cmd_start` takes precedence over `en_wr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hw_flush | input | 1 | Strap: completion is taken from DMA done for every data command |
| en_wr | input | 1 | Enable-mask write strobe |
| en_wdata | input | 9 | Enable-mask write value |
| clr_wr | input | 1 | Status write-one-to-clear strobe |
| clr_data | input | 9 | Bits to clear |
| cmd_start | input | 1 | Start of a new command |
| cmd_has_data | input | 1 | The new command moves data |
| cmd_write | input | 1 | The data direction is host to card |
| req_done | input | 1 | The request has finished |
| ev | input | 9 | Event pulses, laid out as the status bits |
| en_o | output | 9 | Current enable mask |
| sta_o | output | 9 | Current status |
| irq | output | 1 | Level interrupt |
| cmd_err | output | 2 | Command error code |
| dat_err | output | 2 | Data error code |
| cmp_sel | output | 2 | Selected completion source |
| req_end | output | 1 | The selected completion event is pending |

## Verification
The main collision is between an event pulse and a clear that land in the same cycle. The clear can be a write-one-to-clear, a command start or a request end. The bench drives each pair in one cycle and requires the event bit to survive, while the other cleared bits drop. A second collision is between the mask write and the command or request controls. The bench provokes it by asserting them together and judges the result from the mask seen at `en_o` one cycle later.

// File: rtl/sdh_irq_pkg.sv
package sdh_irq_pkg;
  localparam int NEV = 9;
  localparam int B_RESP_OK  = 0;
  localparam int B_RESP_CRC = 1;
  localparam int B_RESP_TMO = 2;
  localparam int B_DAT_CRC  = 3;
  localparam int B_DAT_TMO  = 4;
  localparam int B_RXF_FULL = 5;
  localparam int B_TXF_EMPT = 6;
  localparam int B_DMA_DONE = 7;
  localparam int B_XFER_OK  = 8;

  typedef logic [NEV-1:0] ev_vec_t;

  localparam ev_vec_t ERR_MASK = ev_vec_t'((1 << B_RESP_CRC) | (1 << B_RESP_TMO) |
                                           (1 << B_DAT_CRC) | (1 << B_DAT_TMO) |
                                           (1 << B_RXF_FULL) | (1 << B_TXF_EMPT));

  typedef enum logic [1:0] {ERR_NONE = 2'd0, ERR_IO = 2'd1, ERR_CRC = 2'd2, ERR_TMO = 2'd3} err_code_t;
  typedef enum logic [1:0] {CMP_RESP = 2'd0, CMP_DMA = 2'd1, CMP_XFER = 2'd2} cmp_sel_t;

  function automatic cmp_sel_t f_cmp_sel(input logic has_data, input logic wr, input logic hwf);
    if (!has_data)      return CMP_RESP;
    else if (hwf || wr) return CMP_DMA;
    else                return CMP_XFER;
  endfunction

  function automatic int f_cmp_bit(input cmp_sel_t sel);
    case (sel)
      CMP_DMA:  return B_DMA_DONE;
      CMP_XFER: return B_XFER_OK;
      default:  return B_RESP_OK;
    endcase
  endfunction

  function automatic ev_vec_t f_start_mask(input cmp_sel_t sel);
    return ERR_MASK | (ev_vec_t'(1) << f_cmp_bit(sel));
  endfunction

  function automatic err_code_t f_cmd_err(input ev_vec_t s);
    if (s[B_RXF_FULL] || s[B_TXF_EMPT]) return ERR_IO;
    else if (s[B_RESP_CRC])             return ERR_CRC;
    else if (s[B_RESP_TMO])             return ERR_TMO;
    else                                return ERR_NONE;
  endfunction

  function automatic err_code_t f_dat_err(input ev_vec_t s, input logic has_data);
    if (!has_data)          return ERR_NONE;
    else if (s[B_DAT_CRC])  return ERR_CRC;
    else if (s[B_DAT_TMO])  return ERR_TMO;
    else                    return ERR_NONE;
  endfunction
endpackage

// File: rtl/sdh_irq_ctx.sv
module sdh_irq_ctx
  import sdh_irq_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     hw_flush_i,
  input  logic     en_wr_i,
  input  ev_vec_t  en_wdata_i,
  input  logic     cmd_start_i,
  input  logic     cmd_has_data_i,
  input  logic     cmd_write_i,
  input  logic     req_done_i,
  output ev_vec_t  en_q,
  output logic     has_data_q,
  output cmp_sel_t cmp_sel_q
);
  cmp_sel_t new_sel;
  logic     ctx_load, mask_load;

  assign new_sel   = f_cmp_sel(cmd_has_data_i, cmd_write_i, hw_flush_i);
  assign ctx_load  = cmd_start_i && !req_done_i;
  assign mask_load = en_wr_i && !cmd_start_i && !req_done_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q       <= '0;
      has_data_q <= 1'b0;
      cmp_sel_q  <= CMP_RESP;
    end else if (req_done_i) begin
      en_q       <= '0;
      has_data_q <= 1'b0;
      cmp_sel_q  <= CMP_RESP;
    end else if (ctx_load) begin
      en_q       <= f_start_mask(new_sel);
      has_data_q <= cmd_has_data_i;
      cmp_sel_q  <= new_sel;
    end else if (mask_load) begin
      en_q       <= en_wdata_i;
    end
  end

  // R4
  mask_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mask_load |=> en_q == $past(en_wdata_i));
  // R5
  start_errs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctx_load |=> (en_q & ERR_MASK) == ERR_MASK && $countones(en_q) == 7);
  // R9
  done_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_done_i |=> en_q == '0 && !has_data_q);
endmodule

// File: rtl/sdh_irq_status.sv
module sdh_irq_status
  import sdh_irq_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  ev_vec_t ev_i,
  input  logic    clr_wr_i,
  input  ev_vec_t clr_data_i,
  input  logic    flush_i,
  output ev_vec_t sta_q
);
  ev_vec_t clr_vec;

  always_comb begin
    clr_vec = '0;
    if (flush_i)       clr_vec = '1;
    else if (clr_wr_i) clr_vec = clr_data_i;
  end

  for (genvar b = 0; b < NEV; b++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            sta_q[b] <= 1'b0;
      else if (ev_i[b])      sta_q[b] <= 1'b1;
      else if (clr_vec[b])   sta_q[b] <= 1'b0;
    end
  end

  // R2
  w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr_i && !flush_i) |=> (sta_q & $past(clr_data_i & ~ev_i)) == '0);
  // R3
  ev_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|ev_i) |=> (sta_q & $past(ev_i)) == $past(ev_i));
  // R5
  flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> sta_q == $past(ev_i));
endmodule

// File: rtl/sdh_irq_classify.sv
module sdh_irq_classify
  import sdh_irq_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  ev_vec_t   sta_i,
  input  ev_vec_t   en_i,
  input  logic      has_data_i,
  input  cmp_sel_t  cmp_sel_i,
  output logic      irq_o,
  output err_code_t cmd_err_o,
  output err_code_t dat_err_o,
  output logic      req_end_o
);
  ev_vec_t pend;

  assign pend      = sta_i & en_i;
  assign irq_o     = |pend;
  assign cmd_err_o = f_cmd_err(sta_i);
  assign dat_err_o = f_dat_err(sta_i, has_data_i);
  assign req_end_o = sta_i[f_cmp_bit(cmp_sel_i)];

  // R6
  cmd_io_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_err_o == ERR_IO) |-> (sta_i[B_RXF_FULL] || sta_i[B_TXF_EMPT]));
  // R7
  dat_nodata_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !has_data_i |-> dat_err_o == ERR_NONE);
endmodule

// File: rtl/sdh_irq_top.sv
module sdh_irq_top
  import sdh_irq_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  hw_flush,
  input  logic                  en_wr,
  input  logic [NEV-1:0]        en_wdata,
  input  logic                  clr_wr,
  input  logic [NEV-1:0]        clr_data,
  input  logic                  cmd_start,
  input  logic                  cmd_has_data,
  input  logic                  cmd_write,
  input  logic                  req_done,
  input  logic [NEV-1:0]        ev,
  output logic [NEV-1:0]        en_o,
  output logic [NEV-1:0]        sta_o,
  output logic                  irq,
  output logic [1:0]            cmd_err,
  output logic [1:0]            dat_err,
  output logic [1:0]            cmp_sel,
  output logic                  req_end
);
  ev_vec_t   en_q, sta_q;
  logic      has_data_q, flush_all;
  cmp_sel_t  sel_q;
  err_code_t cerr, derr;

  assign flush_all = cmd_start || req_done;

  sdh_irq_ctx u_ctx (
    .clk(clk), .rst_n(rst_n), .hw_flush_i(hw_flush),
    .en_wr_i(en_wr), .en_wdata_i(en_wdata),
    .cmd_start_i(cmd_start), .cmd_has_data_i(cmd_has_data), .cmd_write_i(cmd_write),
    .req_done_i(req_done), .en_q(en_q), .has_data_q(has_data_q), .cmp_sel_q(sel_q));

  sdh_irq_status u_sta (
    .clk(clk), .rst_n(rst_n), .ev_i(ev), .clr_wr_i(clr_wr), .clr_data_i(clr_data),
    .flush_i(flush_all), .sta_q(sta_q));

  sdh_irq_classify u_cls (
    .clk(clk), .rst_n(rst_n), .sta_i(sta_q), .en_i(en_q), .has_data_i(has_data_q),
    .cmp_sel_i(sel_q), .irq_o(irq), .cmd_err_o(cerr), .dat_err_o(derr), .req_end_o(req_end));

  assign en_o    = en_q;
  assign sta_o   = sta_q;
  assign cmd_err = cerr;
  assign dat_err = derr;
  assign cmp_sel = sel_q;

  // R1
  irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((|(ev & en_q)) && !req_done && !cmd_start && !en_wr) |=> irq);
  // R11
  done_over_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_done && cmd_start) |=> en_o == '0);
endmodule

// File: tb/sdh_irq_top_tb_top.sv
module sdh_irq_top_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic hw_flush = 0, en_wr = 0, clr_wr = 0, cmd_start = 0, cmd_has_data = 0, cmd_write = 0, req_done = 0;
  logic [8:0] en_wdata = '0, clr_data = '0, ev = '0;
  logic [8:0] en_o, sta_o;
  logic irq, req_end;
  logic [1:0] cmd_err, dat_err, cmp_sel;
  int n_run = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  sdh_irq_top dut_i (.clk(clk), .rst_n(rst_n), .hw_flush(hw_flush), .en_wr(en_wr), .en_wdata(en_wdata),
    .clr_wr(clr_wr), .clr_data(clr_data), .cmd_start(cmd_start), .cmd_has_data(cmd_has_data),
    .cmd_write(cmd_write), .req_done(req_done), .ev(ev), .en_o(en_o), .sta_o(sta_o), .irq(irq),
    .cmd_err(cmd_err), .dat_err(dat_err), .cmp_sel(cmp_sel), .req_end(req_end));

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // one clock edge, then drop every strobe
  task automatic tick();
    @(posedge clk); #1;
    en_wr = 0; clr_wr = 0; cmd_start = 0; req_done = 0; ev = '0;
  endtask

  task automatic start_cmd(input logic d, input logic w);
    cmd_start = 1; cmd_has_data = d; cmd_write = w; tick();
  endtask

  task automatic t_reset();
    chk("R10 en", en_o, 0); chk("R10 sta", sta_o, 0); chk("R10 irq", irq, 0);
    chk("R10 cerr", cmd_err, 0); chk("R10 derr", dat_err, 0);
    chk("R10 sel", cmp_sel, 0); chk("R10 end", req_end, 0);
  endtask

  task automatic t_mask_w1c();
    en_wr = 1; en_wdata = 9'h1FF; tick();
    chk("R4 mask", en_o, 9'h1FF);
    ev = 9'h001; tick();
    chk("R3 set", sta_o, 9'h001); chk("R1 irq on", irq, 1);
    en_wr = 1; en_wdata = 9'h000; tick();
    chk("R1 masked", irq, 0); chk("R1 sta kept", sta_o, 9'h001);
    ev = 9'h006; tick();
    clr_wr = 1; clr_data = 9'h003; tick();
    chk("R2 w1c", sta_o, 9'h004);
    clr_wr = 1; clr_data = 9'h004; ev = 9'h004; tick();
    chk("R3 ev beats w1c", sta_o, 9'h004);
    clr_wr = 1; clr_data = 9'h1FF; tick();
    chk("R2 clear all", sta_o, 0);
  endtask

  task automatic t_nodata();
    ev = 9'h018; tick();
    start_cmd(0, 0);
    chk("R5 mask", en_o, 9'h07F); chk("R5 sta clr", sta_o, 0); chk("R8 sel", cmp_sel, 0);
    ev = 9'h001; tick();
    chk("R8 end", req_end, 1); chk("R1 irq", irq, 1);
    ev = 9'h008; tick();
    chk("R7 nodata", dat_err, 0);
    req_done = 1; tick();
    chk("R9 en", en_o, 0); chk("R9 sta", sta_o, 0); chk("R9 irq", irq, 0);
  endtask

  task automatic t_errors();
    hw_flush = 0; start_cmd(1, 0);
    chk("R5 read mask", en_o, 9'h17E); chk("R8 xfer", cmp_sel, 2);
    ev = 9'h004; tick(); chk("R6 tmo", cmd_err, 3);
    ev = 9'h002; tick(); chk("R6 crc", cmd_err, 2);
    ev = 9'h040; tick(); chk("R6 io", cmd_err, 1);
    ev = 9'h010; tick(); chk("R7 tmo", dat_err, 3);
    ev = 9'h008; tick(); chk("R7 crc", dat_err, 2);
    ev = 9'h080; tick(); chk("R8 dma ignored", req_end, 0);
    ev = 9'h100; tick(); chk("R8 xfer end", req_end, 1);
    req_done = 1; tick();
    chk("R9 derr", dat_err, 0); chk("R9 sta", sta_o, 0);
  endtask

  task automatic t_sel();
    hw_flush = 0; start_cmd(1, 1);
    chk("R8 write dma", cmp_sel, 1); chk("R5 write mask", en_o, 9'h0FE);
    hw_flush = 1; start_cmd(1, 0);
    chk("R8 hwf dma", cmp_sel, 1);
    ev = 9'h100; tick(); chk("R8 xfer ignored", req_end, 0);
    ev = 9'h080; tick(); chk("R8 dma end", req_end, 1);
    hw_flush = 0;
    ev = 9'h020; cmd_start = 1; cmd_has_data = 0; cmd_write = 0; tick();
    chk("R3 ev beats start", sta_o, 9'h020);
  endtask

  task automatic t_prio();
    en_wr = 1; en_wdata = 9'h155; cmd_start = 1; cmd_has_data = 0; tick();
    chk("R11 start over wr", en_o, 9'h07F);
    req_done = 1; cmd_start = 1; cmd_has_data = 1; ev = 9'h002; tick();
    chk("R11 done over start", en_o, 0); chk("R3 ev beats done", sta_o, 9'h002);
    chk("R11 no ctx", dat_err, 0);
    en_wr = 1; en_wdata = 9'h0AA; req_done = 1; tick();
    chk("R11 done over wr", en_o, 0);
  endtask

  initial begin
    fork
      begin
        #3; t_reset();
        #10; rst_n = 1; @(posedge clk); #1;
        t_reset();
        t_mask_w1c();
        t_nodata();
        t_errors();
        t_sel();
        t_prio();
      end
      begin
        repeat (5000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule